// File: doc/BRIEF.md
# Stereo Digital Attenuator with Soft Mute and Silence Flag

This block is the per-sample gain stage of a stereo PCM path. On every sample strobe it scales a left and a right signed sample by a host-supplied 12-bit linear attenuation code. It also scales them by a soft-mute level between 0 and 64. The products are registered and held until the next strobe.

A mute request input drives the soft-mute level. When the request goes high, the level falls one step at a time to zero. When the request goes low, the level climbs back to full scale at the same rate. A ramp always runs to its end before the request is looked at again.

A separate watcher raises a silence flag once both channels have carried zero samples for a long unbroken run of strobes. Any nonzero sample on either channel drops the flag at once.

Top module: `pcm_gain_mute`

## Requirements
- R1: With attenuation code 0xFFF and the mute level at full scale (64), each output equals its input sample exactly.
- R2: With attenuation code 0x000, both outputs are 0 for any input sample and any mute level.
- R3: On the clock edge where `sample_valid` is high, each output becomes trunc(sample × code × level / (4095 × 64)), rounded toward zero. The level used is the value the mute level held before that edge. Between strobes the outputs hold their value.
- R4: After reset, both outputs are 0, the zero flag is low and the mute level is 64, so the first strobe at code 0xFFF passes samples unchanged.
- R5: While the block is unmuted at level 64, a high `mute_req` starts a falling ramp. The level drops by one on every 16th strobe and reaches 0 after 1024 strobes.
- R6: While the block is muted at level 0, a low `mute_req` starts a rising ramp. The level rises by one on every 16th strobe and reaches 64 after 1024 strobes.
- R7: Changes on `mute_req` during a ramp do not alter the ramp. Once the ramp ends, the request is sampled again. If the request now disagrees with the reached level, the opposite ramp begins.
- R8: `zero_flag` goes high on the strobe that completes a run of 15435 consecutive strobes in which both samples are zero. It stays high while that run continues.
- R9: A strobe carrying a nonzero sample on either channel clears the run and drives `zero_flag` low on that edge. A zero run on one channel alone never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new stereo sample pair |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| atten_code | input | 12 | Linear gain code; gain is code/4095, code 0 is silence |
| mute_req | input | 1 | High requests a mute; low requests full level |
| out_left | output | 16 | Scaled left sample, registered |
| out_right | output | 16 | Scaled right sample, registered |
| zero_flag | output | 1 | High after a long run of silence on both channels |

## Verification
The bound checker watches the cycle-local rules on every cycle. It checks unity pass-through at full gain, silence at code zero, and that the outputs and the mute level hold between strobes. It also checks that the level never moves more than one step or past its range, that a running ramp neither reverses nor stops early, and that a nonzero sample always drops the silence flag.

Only the bench scenarios can show the long-range behaviour. These are the exact 16-strobe step spacing, the 1024-strobe ramp length, and the request being re-sampled after a ramp finishes. They also include the 15435-strobe silence threshold, the one-channel-only silence case, and the truncation toward zero of the scaled values.

// File: rtl/pcm_gain_pkg.sv
package pcm_gain_pkg;

  typedef enum logic [1:0] {
    MS_OPEN = 2'd0,
    MS_FALL = 2'd1,
    MS_SHUT = 2'd2,
    MS_RISE = 2'd3
  } mute_state_t;

  // Scale one sample: s * c * lv / (fc * fl), truncated toward zero.
  function automatic logic signed [47:0] scale_value(
    input logic signed [47:0] s,
    input logic signed [47:0] c,
    input logic signed [47:0] lv,
    input logic signed [47:0] fc,
    input logic signed [47:0] fl
  );
    logic signed [47:0] num;
    logic signed [47:0] den;
    num = s * c * lv;
    den = fc * fl;
    return num / den;
  endfunction

  // Next level for a ramp step in the given direction.
  function automatic logic [15:0] step_level(input logic [15:0] lv, input logic up);
    return up ? (lv + 16'd1) : (lv - 16'd1);
  endfunction

endpackage

// File: rtl/gain_channel.sv
module gain_channel #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 12,
  parameter int LVL_W    = 7,
  parameter int FULL_LVL = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [CODE_W-1:0]   code,
  input  logic        [LVL_W-1:0]    level,
  output logic signed [SAMPLE_W-1:0] scaled
);
  import pcm_gain_pkg::*;

  localparam int FULL_CODE = (1 << CODE_W) - 1;

  logic signed [47:0] product;

  always_comb begin
    product = scale_value(48'(sample),
                          $signed(48'(code)),
                          $signed(48'(level)),
                          48'(FULL_CODE),
                          48'(FULL_LVL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scaled <= '0;
    end else if (strobe) begin
      scaled <= SAMPLE_W'(product);
    end
  end

endmodule

// File: rtl/mute_ramp.sv
module mute_ramp #(
  parameter int STEPS        = 64,
  parameter int STEP_SAMPLES = 16,
  parameter int LVL_W        = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             mute_req,
  output logic [LVL_W-1:0] level,
  output logic             ramp_down,
  output logic             ramp_up,
  output logic             step_tick
);
  import pcm_gain_pkg::*;

  localparam int SUB_W = (STEP_SAMPLES > 1) ? $clog2(STEP_SAMPLES) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(STEP_SAMPLES - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(STEPS);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

  mute_state_t      state;
  logic [SUB_W-1:0] sub_cnt;
  logic [LVL_W-1:0] next_level;

  assign ramp_down  = (state == MS_FALL);
  assign ramp_up    = (state == MS_RISE);
  assign step_tick  = strobe && (ramp_down || ramp_up) && (sub_cnt == SUB_LAST);
  assign next_level = LVL_W'(step_level(16'(level), ramp_up));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= MS_OPEN;
      level   <= LVL_FULL;
      sub_cnt <= '0;
    end else begin
      unique case (state)
        MS_OPEN: begin
          sub_cnt <= '0;
          if (mute_req) state <= MS_FALL;
        end
        MS_SHUT: begin
          sub_cnt <= '0;
          if (!mute_req) state <= MS_RISE;
        end
        MS_FALL: begin
          if (strobe) begin
            if (sub_cnt == SUB_LAST) begin
              sub_cnt <= '0;
              level   <= next_level;
              if (level == LVL_ONE) state <= MS_SHUT;
            end else begin
              sub_cnt <= sub_cnt + 1'b1;
            end
          end
        end
        MS_RISE: begin
          if (strobe) begin
            if (sub_cnt == SUB_LAST) begin
              sub_cnt <= '0;
              level   <= next_level;
              if (level == LVL_FULL - LVL_ONE) state <= MS_OPEN;
            end else begin
              sub_cnt <= sub_cnt + 1'b1;
            end
          end
        end
        default: state <= MS_OPEN;
      endcase
    end
  end

endmodule

// File: rtl/zero_watch.sv
module zero_watch #(
  parameter int SAMPLE_W = 16,
  parameter int LIMIT    = 15435
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe,
  input  logic signed [SAMPLE_W-1:0] left,
  input  logic signed [SAMPLE_W-1:0] right,
  output logic                       flag,
  output logic                       any_nonzero
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] run_next;

  assign any_nonzero = (left != '0) || (right != '0);

  always_comb begin
    if (any_nonzero)           run_next = '0;
    else if (run_cnt == CNT_MAX) run_next = run_cnt;
    else                       run_next = run_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      flag    <= 1'b0;
    end else if (strobe) begin
      run_cnt <= run_next;
      flag    <= (run_next == CNT_MAX);
    end
  end

endmodule

// File: rtl/pcm_gain_mute.sv
module pcm_gain_mute #(
  parameter int SAMPLE_W     = 16,
  parameter int CODE_W       = 12,
  parameter int MUTE_STEPS   = 64,
  parameter int STEP_SAMPLES = 16,
  parameter int ZERO_LIMIT   = 15435
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic        [CODE_W-1:0]   atten_code,
  input  logic                       mute_req,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       zero_flag
);
  localparam int LVL_W  = $clog2(MUTE_STEPS + 1);
  localparam int N_CHAN = 2;

  logic [LVL_W-1:0] mute_level;
  logic             ramp_down;
  logic             ramp_up;
  logic             step_tick;
  logic             any_nonzero;

  logic signed [SAMPLE_W-1:0] ch_in  [N_CHAN];
  logic signed [SAMPLE_W-1:0] ch_out [N_CHAN];

  assign ch_in[0]  = in_left;
  assign ch_in[1]  = in_right;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  mute_ramp #(
    .STEPS       (MUTE_STEPS),
    .STEP_SAMPLES(STEP_SAMPLES),
    .LVL_W       (LVL_W)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (sample_valid),
    .mute_req (mute_req),
    .level    (mute_level),
    .ramp_down(ramp_down),
    .ramp_up  (ramp_up),
    .step_tick(step_tick)
  );

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    gain_channel #(
      .SAMPLE_W(SAMPLE_W),
      .CODE_W  (CODE_W),
      .LVL_W   (LVL_W),
      .FULL_LVL(MUTE_STEPS)
    ) u_gain (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(sample_valid),
      .sample(ch_in[ch]),
      .code  (atten_code),
      .level (mute_level),
      .scaled(ch_out[ch])
    );
  end

  zero_watch #(
    .SAMPLE_W(SAMPLE_W),
    .LIMIT   (ZERO_LIMIT)
  ) u_zero (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (sample_valid),
    .left       (in_left),
    .right      (in_right),
    .flag       (zero_flag),
    .any_nonzero(any_nonzero)
  );

endmodule

// File: rtl/pcm_gain_mute_checker.sv
module pcm_gain_mute_checker #(
  parameter int SAMPLE_W   = 16,
  parameter int CODE_W     = 12,
  parameter int LVL_W      = 7,
  parameter int MUTE_STEPS = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sample_valid,
  input logic signed [SAMPLE_W-1:0] in_left,
  input logic signed [SAMPLE_W-1:0] in_right,
  input logic        [CODE_W-1:0]   atten_code,
  input logic signed [SAMPLE_W-1:0] out_left,
  input logic signed [SAMPLE_W-1:0] out_right,
  input logic                       zero_flag,
  input logic        [LVL_W-1:0]    level,
  input logic                       ramp_down,
  input logic                       ramp_up,
  input logic                       any_nonzero
);
  localparam logic [LVL_W-1:0]  LVL_FULL  = LVL_W'(MUTE_STEPS);
  localparam logic [CODE_W-1:0] CODE_FULL = '1;

  assert_unity_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && atten_code == CODE_FULL && level == LVL_FULL)
      |=> (out_left == $past(in_left) && out_right == $past(in_right)));

  assert_code_zero_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && atten_code == '0) |=> (out_left == '0 && out_right == '0));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(out_left) && $stable(out_right)));

  assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_FULL);

  assert_level_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(level));

  assert_fall_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_down |=> (level == $past(level) || level == $past(level) - 1'b1));

  assert_rise_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_up |=> (level == $past(level) || level == $past(level) + 1'b1));

  assert_fall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_down && level > LVL_W'(1)) |=> ramp_down);

  assert_rise_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_up && level < LVL_FULL - LVL_W'(1)) |=> ramp_up);

  assert_flag_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> $past(sample_valid));

  assert_nonzero_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && any_nonzero) |=> !zero_flag);

endmodule

bind pcm_gain_mute pcm_gain_mute_checker #(
  .SAMPLE_W  (SAMPLE_W),
  .CODE_W    (CODE_W),
  .LVL_W     (LVL_W),
  .MUTE_STEPS(MUTE_STEPS)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_valid(sample_valid),
  .in_left     (in_left),
  .in_right    (in_right),
  .atten_code  (atten_code),
  .out_left    (out_left),
  .out_right   (out_right),
  .zero_flag   (zero_flag),
  .level       (mute_level),
  .ramp_down   (ramp_down),
  .ramp_up     (ramp_up),
  .any_nonzero (any_nonzero)
);

// File: tb/test_pcm_gain_mute.sv
module test_pcm_gain_mute;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_valid = 1'b0;
  logic signed [15:0] in_left = '0;
  logic signed [15:0] in_right = '0;
  logic        [11:0] atten_code = 12'hFFF;
  logic               mute_req = 1'b0;
  logic signed [15:0] out_left;
  logic signed [15:0] out_right;
  logic               zero_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pcm_gain_mute i_pcm_gain_mute (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .in_left     (in_left),
    .in_right    (in_right),
    .atten_code  (atten_code),
    .mute_req    (mute_req),
    .out_left    (out_left),
    .out_right   (out_right),
    .zero_flag   (zero_flag)
  );

  // left, right, code, expected left, expected right (full mute level)
  localparam int NVEC = 8;
  localparam int VEC [NVEC][5] = '{
    '{ 16384, -16384, 'hFFF,  16384, -16384},
    '{ 32767, -32768, 'hFFF,  32767, -32768},
    '{  4095,  -4095, 'h001,      1,     -1},
    '{ 32767, -32768, 'h001,      8,     -8},
    '{  1000,  -1000, 'h000,      0,      0},
    '{ 32767, -32768, 'h800,  16387, -16388},
    '{  1234,     -7, 'hFFE,   1233,     -6},
    '{ 12345,    100, 'h640,   4823,     39}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Caller stands at a falling edge; returns one falling edge later.
  task automatic strobe(input logic signed [15:0] l, input logic signed [15:0] r);
    in_left = l;
    in_right = r;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  function automatic longint expect_val(input longint s, input longint c, input longint lv);
    longint p;
    p = s * c * lv;
    // truncation toward zero, written via magnitudes
    if (p < 0) return -((-p) / 262080);
    return p / 262080;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: reset state
    check("R4 out_left", out_left, 0);
    check("R4 out_right", out_right, 0);
    check("R4 zero_flag", zero_flag, 0);

    // R1 R2 R3: vector table at full mute level
    for (int i = 0; i < NVEC; i++) begin
      atten_code = 12'(VEC[i][2]);
      strobe(16'(VEC[i][0]), 16'(VEC[i][1]));
      check("R3 table left", out_left, VEC[i][3]);
      check("R3 table right", out_right, VEC[i][4]);
    end

    // R3: outputs hold between strobes
    atten_code = 12'hFFF;
    strobe(16'sd300, -16'sd300);
    in_left = 16'sd5;
    in_right = 16'sd6;
    repeat (3) @(negedge clk);
    check("R3 hold left", out_left, 300);
    check("R3 hold right", out_right, -300);

    // R5: falling ramp
    mute_req = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 16; k++) strobe(16'sd16384, -16'sd16384);
    check("R5 level 64 through strobe 16", out_left, 16384);
    strobe(16'sd16384, -16'sd16384);
    check("R5 first step left", out_left, 16128);
    check("R5 first step right", out_right, -16128);
    for (int k = 18; k <= 40; k++) strobe(16'sd16384, -16'sd16384);
    atten_code = 12'h800;
    strobe(16'sd32767, 16'sd0);
    check("R3 code and level combined", out_left, expect_val(32767, 2048, 62));
    atten_code = 12'hFFF;
    for (int k = 42; k <= 1024; k++) begin
      if (k == 100) mute_req = 1'b0;   // R7: ignored mid-ramp
      strobe(16'sd16384, -16'sd16384);
    end
    check("R5 R7 last falling step left", out_left, 256);
    strobe(16'sd16384, -16'sd16384);
    check("R5 R7 muted after 1024 strobes", out_left, 0);
    check("R5 muted right", out_right, 0);

    // R6 R7: request went low during ramp, so rising ramp starts now
    for (int k = 1026; k <= 1041; k++) strobe(16'sd16384, -16'sd16384);
    check("R6 still silent before first rise", out_left, 0);
    strobe(16'sd16384, -16'sd16384);
    check("R6 R7 first rising step", out_left, 256);
    for (int k = 1043; k <= 2049; k++) strobe(16'sd16384, -16'sd16384);
    check("R6 one below full", out_left, 16128);
    strobe(16'sd16384, -16'sd16384);
    check("R6 full level restored left", out_left, 16384);
    check("R6 full level restored right", out_right, -16384);

    // R7: once open with request low, level stays full
    for (int k = 0; k < 40; k++) strobe(16'sd16384, -16'sd16384);
    check("R7 stays open", out_left, 16384);

    // R2: code zero while at full level
    atten_code = 12'h000;
    strobe(-16'sd32768, 16'sd32767);
    check("R2 silent left", out_left, 0);
    check("R2 silent right", out_right, 0);
    atten_code = 12'hFFF;

    // R8: threshold of the silence run
    strobe(16'sd1, 16'sd1);
    for (int k = 0; k < 15434; k++) strobe(16'sd0, 16'sd0);
    check("R8 flag low one short", zero_flag, 0);
    strobe(16'sd0, 16'sd0);
    check("R8 flag high at threshold", zero_flag, 1);
    strobe(16'sd0, 16'sd0);
    check("R8 flag stays high", zero_flag, 1);

    // R9: nonzero right clears at once
    strobe(16'sd0, 16'sd5);
    check("R9 right nonzero clears", zero_flag, 0);

    // R9: one channel silent alone never raises the flag
    for (int k = 0; k < 15436; k++) strobe(16'sd3, 16'sd0);
    check("R9 left active blocks flag", zero_flag, 0);

    // R8 R9: new run then a negative left sample
    for (int k = 0; k < 15435; k++) strobe(16'sd0, 16'sd0);
    check("R8 second run high", zero_flag, 1);
    strobe(-16'sd1, 16'sd0);
    check("R9 left nonzero clears", zero_flag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule